// File: doc/BRIEF.md
# Dual-Channel Sample Packer with Fill Interrupt

This block accepts in-phase and quadrature samples, 24 bits each, arriving as pairs from a capture path. It packs both channels into one shared 32-bit-wide synchronous buffer. The in-phase word goes in first and the quadrature word follows on the next cycle, and each word carries its sample in the low 24 bits with the top byte zero. A host drains the buffer through a simple read port, one word per request.

The block compares the number of stored words against a programmable threshold. When enough data has collected, it raises an interrupt request so the host can start a burst transfer. The request holds until the host clears it. It fires again only after the buffer has been drained below the threshold and then refilled to it. A pair that would not fit is dropped whole, and a sticky overflow flag records the loss.

Top module: `iq_packer`

## Requirements
- R1: After reset, fillLevel is 0 and irq, overflow and rdData are all 0.
- R2: An accepted pair writes zero-extended I ({8'h00, I}) in the cycle sampleValid is sampled and zero-extended Q in the next cycle. fillLevel rises by one at each of those two edges.
- R3: A sampleValid sampled in the cycle directly after an accepted pair (the Q write cycle) is ignored and stores nothing.
- R4: A read request sampled on an edge updates rdData on that edge with the oldest stored word and removes it. Words come out in write order, and rdData holds its value when no read is requested.
- R5: A read request while fillLevel is 0 sets rdData to 0 and consumes nothing: the next stored word is still returned by the following read.
- R6: With a non-zero threshold and the interrupt armed, irq rises one cycle after fillLevel first equals or exceeds threshold. A threshold of 0 never raises irq.
- R7: Once raised, irq stays high until irqClear is sampled high, and it is low in the following cycle.
- R8: After irq has fired, it cannot fire again until fillLevel has dropped below threshold. A clear while the level is still at or above threshold leaves irq low even as more data arrives.
- R9: A pair offered when fewer than two entries are free is dropped whole (neither word is stored), and overflow goes high. Overflow stays high until reset.
- R10: fillLevel equals the number of stored words and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample pair is present on sampleI/sampleQ |
| sampleI | input | SAMPLE_W | In-phase sample |
| sampleQ | input | SAMPLE_W | Quadrature sample |
| rdEn | input | 1 | Read request, one word per cycle |
| rdData | output | WORD_W | Registered read word, zero on an empty read |
| threshold | input | LW | Fill level that raises the interrupt (0 disables it) |
| irqClear | input | 1 | Host clear pulse for irq |
| irq | output | 1 | Interrupt request |
| overflow | output | 1 | Sticky flag for a dropped pair |
| fillLevel | output | LW | Number of words currently stored |

## Verification
A wrong read or write pointer shows up on the first read after the bad step. The word returned is then out of order, repeated, or a stale Q value appears where an I value belongs, so the scoreboard reports it within one read. A wrong count or arming state shows up as fillLevel mismatches after each pair, or as irq rising a cycle early, late or a second time without a drain below the threshold. A bad free-space decision shows up as a word that was never expected coming out after an overflow, or as the overflow flag staying low.

// File: rtl/iqpk_pkg.sv
package iqpk_pkg;
  // Strobes issued by the control to the storage datapath each cycle.
  typedef struct packed {
    logic wrI;     // store zero-extended I sample, latch Q
    logic wrQ;     // store latched Q sample
    logic rdDo;    // pop oldest word into rdData
    logic rdZero;  // read on empty buffer: load zero, pop nothing
  } iqpk_strobe_t;
endpackage

// File: rtl/iqpk_datapath.sv
module iqpk_datapath
  import iqpk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 4096,
  parameter int LW       = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  iqpk_strobe_t        stb,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  output logic [LW-1:0]       fillLevel,
  output logic [WORD_W-1:0]   rdData
);
  localparam int AW = $clog2(DEPTH);

  logic [WORD_W-1:0]   store [DEPTH];
  logic [AW-1:0]       wrPtr;
  logic [AW-1:0]       rdPtr;
  logic [SAMPLE_W-1:0] qHold;
  logic [WORD_W-1:0]   wrWord;
  logic                wrAny;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wrAny  = stb.wrI | stb.wrQ;
  assign wrWord = stb.wrQ ? WORD_W'(qHold) : WORD_W'(sampleI);

  always_ff @(posedge clk) begin
    if (wrAny) store[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      qHold     <= '0;
      fillLevel <= '0;
      rdData    <= '0;
    end else begin
      if (stb.wrI) qHold <= sampleQ;
      if (wrAny) wrPtr <= nextPtr(wrPtr);
      if (stb.rdDo) begin
        rdData <= store[rdPtr];
        rdPtr  <= nextPtr(rdPtr);
      end else if (stb.rdZero) begin
        rdData <= '0;
      end
      fillLevel <= fillLevel + LW'(wrAny) - LW'(stb.rdDo);
    end
  end
endmodule

// File: rtl/iqpk_ctrl.sv
module iqpk_ctrl
  import iqpk_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          rdEn,
  input  logic          irqClear,
  input  logic [LW-1:0] threshold,
  input  logic [LW-1:0] fillLevel,
  output iqpk_strobe_t  stb,
  output logic          irq,
  output logic          overflow
);
  logic qPending;
  logic armed;
  logic roomOk;
  logic offer;
  logic accept;
  logic reached;

  assign roomOk  = fillLevel <= LW'(DEPTH - 2);
  assign offer   = sampleValid && !qPending;
  assign accept  = offer && roomOk;
  assign reached = (threshold != '0) && (fillLevel >= threshold);

  always_comb begin
    stb        = '0;
    stb.wrI    = accept;
    stb.wrQ    = qPending;
    stb.rdDo   = rdEn && (fillLevel != '0);
    stb.rdZero = rdEn && (fillLevel == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qPending <= 1'b0;
      overflow <= 1'b0;
      armed    <= 1'b1;
      irq      <= 1'b0;
    end else begin
      qPending <= accept;
      if (offer && !roomOk) overflow <= 1'b1;

      if (irqClear)            irq <= 1'b0;
      else if (armed && reached) irq <= 1'b1;

      if (!reached)                           armed <= 1'b1;
      else if (armed && !irqClear)            armed <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_packer.sv
module iq_packer
  import iqpk_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int DEPTH    = 4096,
  parameter int LW       = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleI,
  input  logic [SAMPLE_W-1:0] sampleQ,
  input  logic                rdEn,
  output logic [WORD_W-1:0]   rdData,
  input  logic [LW-1:0]       threshold,
  input  logic                irqClear,
  output logic                irq,
  output logic                overflow,
  output logic [LW-1:0]       fillLevel
);
  iqpk_strobe_t stb;

  iqpk_ctrl #(.DEPTH(DEPTH), .LW(LW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdEn(rdEn),
    .irqClear(irqClear), .threshold(threshold), .fillLevel(fillLevel),
    .stb(stb), .irq(irq), .overflow(overflow)
  );

  iqpk_datapath #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .DEPTH(DEPTH), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sampleI(sampleI), .sampleQ(sampleQ),
    .fillLevel(fillLevel), .rdData(rdData)
  );
endmodule

// File: rtl/iq_packer_chk.sv
module iq_packer_chk #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4096,
  parameter int LW     = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic [LW-1:0]     threshold,
  input logic              irqClear,
  input logic              irq,
  input logic              overflow,
  input logic [LW-1:0]     fillLevel
);
  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LW'(DEPTH));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (LW+1)'(fillLevel) <= (LW+1)'($past(fillLevel)) + 1);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fillLevel == '0) |=> (rdData == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(threshold) != '0) && ($past(fillLevel) >= $past(threshold)));

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqClear |=> !irq);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(sampleValid) && ($past(fillLevel) > LW'(DEPTH - 2)));
endmodule

bind iq_packer iq_packer_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdEn(rdEn), .rdData(rdData),
  .threshold(threshold), .irqClear(irqClear), .irq(irq), .overflow(overflow),
  .fillLevel(fillLevel)
);

// File: tb/iq_packer_bench.sv
`timescale 1ns/1ps
module iq_packer_bench;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH) + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleI = '0;
  logic [23:0] sampleQ = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic [LW-1:0] threshold = '0;
  logic        irqClear = 1'b0;
  logic        irq;
  logic        overflow;
  logic [LW-1:0] fillLevel;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  int  expCount = 0;
  logic rdSeen = 1'b0;
  bit  done = 0;

  always #2 clk = ~clk;

  iq_packer #(.DEPTH(DEPTH)) u_iq_packer (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleI(sampleI),
    .sampleQ(sampleQ), .rdEn(rdEn), .rdData(rdData), .threshold(threshold),
    .irqClear(irqClear), .irq(irq), .overflow(overflow), .fillLevel(fillLevel)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Driver: offers one pair, then idles one cycle so the Q write completes.
  task automatic sendPair(input logic [23:0] iVal, input logic [23:0] qVal);
    @(negedge clk);
    sampleValid = 1'b1; sampleI = iVal; sampleQ = qVal;
    if (DEPTH - expCount >= 2) begin
      expQ.push_back({8'h00, iVal});
      expQ.push_back({8'h00, qVal});
      expCount += 2;
    end
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic readWord();
    @(negedge clk);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
  endtask

  // Monitor: compares each read result against the scoreboard (R4, R5).
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      logic [31:0] exp;
      if (expQ.size() == 0) begin
        exp = 32'h0;
        check(rdData == exp, "R5 empty read", rdData, exp);
      end else begin
        exp = expQ.pop_front();
        expCount--;
        check(rdData == exp, "R4 read order", rdData, exp);
        check(rdData[31:24] == 8'h00, "R2 upper byte", rdData[31:24], 0);
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fillLevel == 0, "R1 level", fillLevel, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);
    check(rdData == 0, "R1 rdData", rdData, 0);
    rstN = 1'b1;
    threshold = LW'(6);

    // R2 interleave timing: I then Q on consecutive edges
    @(negedge clk);
    sampleValid = 1'b1; sampleI = 24'hA1B2C3; sampleQ = 24'h0F0E0D;
    expQ.push_back(32'h00A1B2C3); expQ.push_back(32'h000F0E0D); expCount += 2;
    @(negedge clk);
    sampleValid = 1'b0;
    check(fillLevel == 1, "R2 level after I", fillLevel, 1);
    @(negedge clk);
    check(fillLevel == 2, "R2 level after Q", fillLevel, 2);

    sendPair(24'hFFFFFF, 24'h800001);
    check(fillLevel == 4, "R10 level", fillLevel, 4);
    check(irq == 0, "R6 below threshold", irq, 0);

    // R6: third pair reaches 6 at the Q edge, irq rises one edge later
    @(negedge clk);
    sampleValid = 1'b1; sampleI = 24'h123456; sampleQ = 24'h654321;
    expQ.push_back(32'h00123456); expQ.push_back(32'h00654321); expCount += 2;
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    check(fillLevel == 6 && irq == 0, "R6 not yet", irq, 0);
    @(negedge clk);
    check(irq == 1, "R6 irq raised", irq, 1);

    // R7 holds until cleared
    repeat (5) @(negedge clk);
    check(irq == 1, "R7 irq held", irq, 1);
    pulseClear();
    check(irq == 0, "R7 irq cleared", irq, 0);

    // R8 no re-fire while still at or above threshold
    sendPair(24'h000011, 24'h000022);
    repeat (2) @(negedge clk);
    check(irq == 0, "R8 no refire", irq, 0);

    // drain below threshold, then refill: fires again
    repeat (4) readWord();
    check(fillLevel == 4, "R10 level after reads", fillLevel, 4);
    sendPair(24'h333333, 24'h444444);
    @(negedge clk);
    check(irq == 1, "R8 refire after drain", irq, 1);
    pulseClear();

    // R3 back-to-back offer: second pair ignored
    @(negedge clk);
    sampleValid = 1'b1; sampleI = 24'hABCDEF; sampleQ = 24'h010203;
    expQ.push_back(32'h00ABCDEF); expQ.push_back(32'h00010203); expCount += 2;
    @(negedge clk);
    sampleI = 24'hDEAD00; sampleQ = 24'hBEEF00;
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    check(fillLevel == 8, "R3 ignored pair", fillLevel, 8);

    // drain everything, then R5 empty read leaves pointer alone
    while (expQ.size() > 0) readWord();
    check(fillLevel == 0, "R10 empty", fillLevel, 0);
    readWord();
    check(fillLevel == 0, "R5 level stays 0", fillLevel, 0);
    sendPair(24'h5A5A5A, 24'hA5A5A5);
    readWord();
    readWord();

    // R9 overflow: fill to DEPTH, next pair dropped
    threshold = '0;
    pulseClear();
    for (int k = 0; k < DEPTH / 2; k++) sendPair(24'(k * 3 + 1), 24'(k * 5 + 2));
    check(fillLevel == LW'(DEPTH), "R10 full", fillLevel, DEPTH);
    check(overflow == 0, "R9 no overflow yet", overflow, 0);
    sendPair(24'h777777, 24'h888888);
    check(overflow == 1, "R9 overflow set", overflow, 1);
    check(fillLevel == LW'(DEPTH), "R9 pair dropped", fillLevel, DEPTH);
    check(irq == 0, "R6 zero threshold never fires", irq, 0);
    while (expQ.size() > 0) readWord();
    readWord();
    check(overflow == 1, "R9 overflow sticky", overflow, 1);
    check(fillLevel == 0, "R10 drained", fillLevel, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule